// File: doc/BRIEF.md
# Second-Operand Shifter with Carry Generation

This combinational unit prepares the second operand of a 32-bit integer datapath. On its register path it takes a source word, a shift kind, a shift amount and the current carry flag. It returns the shifted word, a carry-out bit and a qualifier that says whether that carry-out should replace the flag. Whether the flag is actually written is left to the downstream unit. The source word itself is never modified; only the presented result is shifted.

On its immediate path the unit accepts a constant that has already been expanded to 32 bits, together with a marker saying whether it was formed by rotating an 8-bit value. The constant passes straight through. It produces a valid carry only when it is both rotated and larger than 255.

An amount outside the legal range for the chosen kind raises a flag. In that case the source passes through unchanged and no carry is produced. Instruction decode, the ALU, the flag register and constant expansion all live outside this block.

Top module: `opsh_unit`

## Requirements
- R1: `kind` is encoded as LSL=0, LSR=1, ASR=2, ROR=3, RRX=4; codes 5 to 7 are unsupported. On the register path `amount_bad` is 1 exactly when the amount is out of range: LSL accepts 0..31, LSR and ASR accept 1..32, ROR accepts 1..31, RRX accepts any amount, and an unsupported code rejects every amount.
- R2: LSL by 0 (the omitted shift) returns the source unchanged with `carry_valid`=0.
- R3: LSL by n (1..31) returns the source shifted left n places with zero fill; the carry-out is source bit 32-n.
- R4: LSR by n (1..32) returns the source shifted right with zero fill; the carry-out is source bit n-1, so a shift of 32 gives zero with carry equal to bit 31.
- R5: ASR by n (1..32) fills with source bit 31; the carry-out is source bit n-1, so a shift of 32 gives 32 copies of bit 31 and carry equal to bit 31.
- R6: ROR by n (1..31) rotates the source right; the carry-out equals result bit 31.
- R7: RRX returns {carry_in, source[31:1]} with carry-out source bit 0; the amount input has no effect.
- R8: When `amount_bad` is 1, the operand equals the source and `carry_valid` is 0.
- R9: Whenever `carry_valid` is 0, `carry_out` equals `carry_in`, so a flag update with this value leaves the flag unchanged.
- R10: With `use_imm`=1 the operand equals `imm_value` and `amount_bad` is 0. `carry_valid` is 1 only when `imm_rotated`=1 and `imm_value` > 255, and then `carry_out` is `imm_value` bit 31. `kind` and `amount` have no effect on this path.
- R11: `carry_valid` is 1 for every legal nonzero LSL, LSR, ASR and ROR shift and for RRX.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src | input | 32 | Register value to be shifted |
| kind | input | 3 | Shift kind code |
| amount | input | 6 | Shift distance |
| carry_in | input | 1 | Current carry flag |
| use_imm | input | 1 | Select the immediate path |
| imm_value | input | 32 | Pre-expanded immediate constant |
| imm_rotated | input | 1 | Constant was formed by rotating an 8-bit value |
| operand | output | 32 | Shifted or immediate result |
| carry_out | output | 1 | Carry produced by the operation |
| carry_valid | output | 1 | Carry-out should update the flag |
| amount_bad | output | 1 | Amount illegal for the selected kind |

## Verification
Two checks can apply to the same input: the range check and the carry selection. An out-of-range amount must suppress the barrel's carry, and it must also return the source unshifted. The bench provokes this by sweeping every amount from 0 to 63 for each kind, including 32 for LSR and ASR and 32 for LSL and ROR. It judges each result against a behavioural model that treats legality and shifting as separate decisions. The immediate path is exercised the same way: a constant is presented with a kind/amount pair that would be illegal on its own, and the bench confirms that neither the amount flag nor the shifter leaks through.

// File: rtl/opsh_pkg.sv
package opsh_pkg;
  typedef enum logic [2:0] {
    SK_LSL = 3'd0,
    SK_LSR = 3'd1,
    SK_ASR = 3'd2,
    SK_ROR = 3'd3,
    SK_RRX = 3'd4
  } shift_kind_e;
endpackage

// File: rtl/opsh_range_check.sv
module opsh_range_check
  import opsh_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W) + 1
) (
  input  logic [2:0]       kind,
  input  logic [AMT_W-1:0] amount,
  output logic             bad,
  output logic             pass_thru
);
  localparam logic [AMT_W-1:0] MAX_LEFT  = AMT_W'(DATA_W - 1);
  localparam logic [AMT_W-1:0] MAX_RIGHT = AMT_W'(DATA_W);

  logic zero_amt;
  assign zero_amt = (amount == '0);

  always_comb begin
    bad       = 1'b0;
    pass_thru = 1'b0;
    unique case (kind)
      SK_LSL: begin
        bad       = (amount > MAX_LEFT);
        pass_thru = zero_amt;
      end
      SK_LSR, SK_ASR: bad = zero_amt || (amount > MAX_RIGHT);
      SK_ROR:         bad = zero_amt || (amount > MAX_LEFT);
      SK_RRX:         bad = 1'b0;
      default:        bad = 1'b1;
    endcase
  end

  always_comb begin
    if (pass_thru) assert_pass_is_legal_R2: assert (!bad);
  end
endmodule

// File: rtl/opsh_barrel.sv
module opsh_barrel #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] data,
  input  logic [AMT_W-1:0]  amt,
  input  logic              rotate,
  input  logic              fill,
  output logic [DATA_W-1:0] result,
  output logic              guard
);
  localparam int VW = DATA_W + 1;

  // Each stage carries the data word plus one guard bit below it; the guard
  // ends up holding the last bit that fell off the low end.
  logic [VW-1:0] stg [0:AMT_W];

  assign stg[0] = {data, 1'b0};

  for (genvar i = 0; i < AMT_W; i++) begin : g_stage
    localparam int S = 1 << i;
    logic [DATA_W-1:0] rot_w;
    if (S < DATA_W) begin : g_rot
      assign rot_w = {stg[i][S:1], stg[i][DATA_W:S+1]};
    end else begin : g_rot_id
      assign rot_w = stg[i][DATA_W:1];
    end
    always_comb begin
      if (!amt[i])     stg[i+1] = stg[i];
      else if (rotate) stg[i+1] = {rot_w, 1'b0};
      else             stg[i+1] = {{S{fill}}, stg[i][VW-1:S]};
    end
  end

  assign result = stg[AMT_W][VW-1:1];
  assign guard  = stg[AMT_W][0];

  always_comb begin
    if (rotate)
      assert_rotate_keeps_ones_R6: assert ($countones(result) == $countones(data));
    if (!rotate && !fill && (amt != '0))
      assert_logical_fill_zero_R4: assert (result[DATA_W-1] == 1'b0);
  end
endmodule

// File: rtl/opsh_imm_carry.sv
module opsh_imm_carry #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] imm_value,
  input  logic              imm_rotated,
  output logic              valid,
  output logic              bit_out
);
  localparam logic [DATA_W-1:0] BYTE_MAX = DATA_W'(255);

  assign valid   = imm_rotated && (imm_value > BYTE_MAX);
  assign bit_out = imm_value[DATA_W-1];

  always_comb begin
    if (valid) assert_imm_wide_R10: assert (imm_value[DATA_W-1:8] != '0);
  end
endmodule

// File: rtl/opsh_unit.sv
module opsh_unit
  import opsh_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] src,
  input  logic [2:0]        kind,
  input  logic [AMT_W-1:0]  amount,
  input  logic              carry_in,
  input  logic              use_imm,
  input  logic [DATA_W-1:0] imm_value,
  input  logic              imm_rotated,
  output logic [DATA_W-1:0] operand,
  output logic              carry_out,
  output logic              carry_valid,
  output logic              amount_bad
);
  logic rng_bad, rng_pass;
  logic is_lsl, is_rot, is_rrx, fill_bit;
  logic [DATA_W-1:0] bar_in, bar_out, shifted;
  logic bar_guard, shift_carry;
  logic imm_valid, imm_bit;

  opsh_range_check #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_range (
    .kind(kind), .amount(amount), .bad(rng_bad), .pass_thru(rng_pass)
  );

  assign is_lsl   = (kind == SK_LSL);
  assign is_rot   = (kind == SK_ROR);
  assign is_rrx   = (kind == SK_RRX);
  assign fill_bit = (kind == SK_ASR) && src[DATA_W-1];

  // Left shifts reuse the right-shifting barrel on a bit-reversed word.
  always_comb begin
    for (int b = 0; b < DATA_W; b++) bar_in[b] = is_lsl ? src[DATA_W-1-b] : src[b];
  end

  opsh_barrel #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_barrel (
    .data(bar_in), .amt(amount), .rotate(is_rot), .fill(fill_bit),
    .result(bar_out), .guard(bar_guard)
  );

  always_comb begin
    for (int b = 0; b < DATA_W; b++) shifted[b] = is_lsl ? bar_out[DATA_W-1-b] : bar_out[b];
  end

  assign shift_carry = is_rot ? bar_out[DATA_W-1] : bar_guard;

  opsh_imm_carry #(.DATA_W(DATA_W)) u_imm (
    .imm_value(imm_value), .imm_rotated(imm_rotated),
    .valid(imm_valid), .bit_out(imm_bit)
  );

  always_comb begin
    operand     = src;
    carry_out   = carry_in;
    carry_valid = 1'b0;
    amount_bad  = 1'b0;
    if (use_imm) begin
      operand     = imm_value;
      carry_valid = imm_valid;
      carry_out   = imm_valid ? imm_bit : carry_in;
    end else if (rng_bad) begin
      amount_bad = 1'b1;
    end else if (rng_pass) begin
      operand = src;
    end else if (is_rrx) begin
      operand     = {carry_in, src[DATA_W-1:1]};
      carry_out   = src[0];
      carry_valid = 1'b1;
    end else begin
      operand     = shifted;
      carry_out   = shift_carry;
      carry_valid = 1'b1;
    end
  end

  always_comb begin
    if (!carry_valid) assert_hold_flag_R9: assert (carry_out == carry_in);
    if (amount_bad) assert_bad_passes_src_R8: assert (operand == src && !carry_valid);
    if (use_imm) assert_imm_no_bad_R10: assert (!amount_bad && operand == imm_value);
    if (!use_imm && is_rot && carry_valid)
      assert_ror_carry_msb_R6: assert (carry_out == operand[DATA_W-1]);
  end
endmodule

// File: tb/opsh_unit_bench.sv
module opsh_unit_bench;
  localparam int DW = 32;
  localparam int AW = 6;

  typedef struct packed {
    logic          imm;
    logic          rot;
    logic [2:0]    kind;
    logic [AW-1:0] amt;
    logic          cin;
    logic [DW-1:0] val;
    logic [DW-1:0] x_out;
    logic          x_cout;
    logic          x_valid;
    logic          x_bad;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TABLE [NV] = '{
    '{1'b0,1'b0,3'd0,6'd0, 1'b1,32'h12345678,32'h12345678,1'b1,1'b0,1'b0}, // R2
    '{1'b0,1'b0,3'd0,6'd4, 1'b0,32'hF0000001,32'h00000010,1'b1,1'b1,1'b0}, // R3
    '{1'b0,1'b0,3'd1,6'd32,1'b0,32'h80000000,32'h00000000,1'b1,1'b1,1'b0}, // R4
    '{1'b0,1'b0,3'd1,6'd1, 1'b0,32'h00000001,32'h00000000,1'b1,1'b1,1'b0}, // R4
    '{1'b0,1'b0,3'd2,6'd32,1'b0,32'h80000000,32'hFFFFFFFF,1'b1,1'b1,1'b0}, // R5
    '{1'b0,1'b0,3'd2,6'd4, 1'b0,32'h8000000F,32'hF8000000,1'b1,1'b1,1'b0}, // R5
    '{1'b0,1'b0,3'd3,6'd8, 1'b0,32'h000000AB,32'hAB000000,1'b1,1'b1,1'b0}, // R6
    '{1'b0,1'b0,3'd3,6'd1, 1'b1,32'h00000002,32'h00000001,1'b0,1'b1,1'b0}, // R6
    '{1'b0,1'b0,3'd4,6'd0, 1'b1,32'h00000003,32'h80000001,1'b1,1'b1,1'b0}, // R7
    '{1'b0,1'b0,3'd4,6'd17,1'b0,32'hFFFFFFFE,32'h7FFFFFFF,1'b0,1'b1,1'b0}, // R7
    '{1'b0,1'b0,3'd0,6'd32,1'b0,32'hDEADBEEF,32'hDEADBEEF,1'b0,1'b0,1'b1}, // R8
    '{1'b0,1'b0,3'd1,6'd0, 1'b1,32'h00000001,32'h00000001,1'b1,1'b0,1'b1}, // R8
    '{1'b0,1'b0,3'd3,6'd32,1'b1,32'h0000F00D,32'h0000F00D,1'b1,1'b0,1'b1}, // R1
    '{1'b0,1'b0,3'd2,6'd33,1'b0,32'h80000000,32'h80000000,1'b0,1'b0,1'b1}, // R1
    '{1'b0,1'b0,3'd5,6'd1, 1'b1,32'h00000010,32'h00000010,1'b1,1'b0,1'b1}, // R1
    '{1'b1,1'b1,3'd0,6'd40,1'b0,32'h000003FC,32'h000003FC,1'b0,1'b1,1'b0}, // R10
    '{1'b1,1'b1,3'd6,6'd0, 1'b0,32'hFF000000,32'hFF000000,1'b1,1'b1,1'b0}, // R10
    '{1'b1,1'b1,3'd1,6'd0, 1'b1,32'h000000FF,32'h000000FF,1'b1,1'b0,1'b0}, // R10
    '{1'b1,1'b0,3'd2,6'd4, 1'b0,32'h80000000,32'h80000000,1'b0,1'b0,1'b0}, // R10
    '{1'b1,1'b1,3'd3,6'd9, 1'b1,32'h00000100,32'h00000100,1'b0,1'b1,1'b0}  // R10
  };

  logic clk;
  logic rst_n;
  logic [DW-1:0] src, imm_value, operand;
  logic [2:0] kind;
  logic [AW-1:0] amount;
  logic carry_in, use_imm, imm_rotated, carry_out, carry_valid, amount_bad;

  int checks;
  int fails;
  bit done;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  opsh_unit u_opsh_unit (
    .src(src), .kind(kind), .amount(amount), .carry_in(carry_in),
    .use_imm(use_imm), .imm_value(imm_value), .imm_rotated(imm_rotated),
    .operand(operand), .carry_out(carry_out), .carry_valid(carry_valid),
    .amount_bad(amount_bad)
  );

  // Behavioural model: returns {bad, valid, cout, out}
  function automatic logic [DW+2:0] model(input logic [2:0] k, input int n,
                                          input logic [DW-1:0] s, input logic ci);
    logic [DW-1:0] o;
    logic bad, v, co;
    o = s; v = 1'b0; co = ci; bad = 1'b0;
    case (k)
      3'd0: if (n > 31) bad = 1'b1;
            else if (n != 0) begin o = s << n; co = s[32-n]; v = 1'b1; end
      3'd1: if (n < 1 || n > 32) bad = 1'b1;
            else begin o = s >> n; co = s[n-1]; v = 1'b1; end
      3'd2: if (n < 1 || n > 32) bad = 1'b1;
            else begin o = DW'($signed(s) >>> n); co = s[n-1]; v = 1'b1; end
      3'd3: if (n < 1 || n > 31) bad = 1'b1;
            else begin o = (s >> n) | (s << (32 - n)); co = o[31]; v = 1'b1; end
      3'd4: begin o = {ci, s[31:1]}; co = s[0]; v = 1'b1; end
      default: bad = 1'b1;
    endcase
    return {bad, v, co, o};
  endfunction

  task automatic check(input string req, input logic [DW-1:0] xo, input logic xc,
                       input logic xv, input logic xb);
    checks++;
    if (operand !== xo || carry_out !== xc || carry_valid !== xv || amount_bad !== xb) begin
      fails++;
      $display("FAIL %s: kind=%0d amt=%0d src=%h imm=%0b got out=%h c=%0b v=%0b bad=%0b exp out=%h c=%0b v=%0b bad=%0b",
               req, kind, amount, src, use_imm, operand, carry_out, carry_valid, amount_bad,
               xo, xc, xv, xb);
    end
  endtask

  task automatic apply(input logic im, input logic rt, input logic [2:0] k,
                       input logic [AW-1:0] a, input logic ci, input logic [DW-1:0] v);
    @(posedge clk);
    use_imm = im; imm_rotated = rt; kind = k; amount = a; carry_in = ci;
    if (im) begin imm_value = v; src = ~v; end
    else begin src = v; imm_value = ~v; end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not complete, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] pats [6];
    logic [DW+2:0] r;
    checks = 0; fails = 0; done = 0;
    pats[0] = 32'h0; pats[1] = 32'hFFFFFFFF; pats[2] = 32'h80000000;
    pats[3] = 32'h00000001; pats[4] = 32'hA5C3_1E69; pats[5] = 32'h5A3C_E196;

    // Reset phase: inputs held at zero, output must be quiet (R2, R9)
    rst_n = 1'b0;
    src = '0; imm_value = '0; kind = 3'd0; amount = '0;
    carry_in = 1'b0; use_imm = 1'b0; imm_rotated = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R2 reset", 32'h0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;

    // Vector table
    for (int i = 0; i < NV; i++) begin
      apply(TABLE[i].imm, TABLE[i].rot, TABLE[i].kind, TABLE[i].amt, TABLE[i].cin, TABLE[i].val);
      check("R1-R10 table", TABLE[i].x_out, TABLE[i].x_cout, TABLE[i].x_valid, TABLE[i].x_bad);
    end

    // Full sweep of every kind and amount against the model (R1 R3 R4 R5 R6 R8 R9 R11)
    for (int k = 0; k < 8; k++) begin
      for (int a = 0; a < 64; a++) begin
        for (int p = 0; p < 6; p++) begin
          logic ci;
          ci = ((a + p + k) % 2) == 1;
          apply(1'b0, 1'b0, 3'(k), 6'(a), ci, pats[p]);
          r = model(3'(k), a, pats[p], ci);
          check("R1 R3 R4 R5 R6 R7 R8 R9 R11 sweep", r[DW-1:0], r[DW], r[DW+1], r[DW+2]);
        end
      end
    end

    // RRX ignores amount (R7)
    for (int a = 0; a < 64; a += 7) begin
      apply(1'b0, 1'b0, 3'd4, 6'(a), 1'b1, 32'h0000_0006);
      check("R7 rrx amount ignored", 32'h8000_0003, 1'b0, 1'b1, 1'b0);
    end

    // Immediate path ignores kind/amount (R10)
    for (int k = 0; k < 8; k++) begin
      apply(1'b1, 1'b1, 3'(k), 6'(63 - k), 1'b0, 32'h8000_0001);
      check("R10 imm rotated wide", 32'h8000_0001, 1'b1, 1'b1, 1'b0);
      apply(1'b1, 1'b0, 3'(k), 6'(63 - k), 1'b1, 32'h0000_1000);
      check("R10 imm unrotated", 32'h0000_1000, 1'b1, 1'b0, 1'b0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule